// File: doc/BRIEF.md
# Mailbox Byte Event Interrupt Generator

This block raises one side's interrupt line from mailbox byte flags. It reads the byte-full flags of that side's incoming mailboxes and the byte-full flags of its outgoing mailboxes, one bit per byte. Software sets up two separate conditions. The arrival condition fires when one chosen byte of one chosen incoming mailbox goes from empty to full. The drain condition fires when one chosen byte of one chosen outgoing mailbox goes from full to empty. That second event means the far side has taken the data, so more can be written.

Each condition has an enable, a mailbox select and a byte select. It also has a sticky pending bit, which software clears by pulsing a write-one clear input. The interrupt output is active low and stays asserted while either pending bit is set. A design uses one instance per side, and each instance is configured on its own. The flag storage sits outside this block.

Top module: `mbx_event_irq`

## Requirements
- R1: In the cycle after a synchronous reset, both pending bits are 0 and `irq_n` is 1. The first clock edge after reset is used only to capture the selected flags and cannot set a pending bit, whatever the flag values are.
- R2: A condition watches flag bit index `mb_sel*4 + byte_sel`, with mailbox and byte counted from 0. For example, mailbox 2, byte 1 is bit 9.
- R3: The arrival pending bit goes high after the clock edge at which the selected incoming flag is sampled 1, provided it was sampled 0 at the edge before and the arrival enable is 1.
- R4: The drain pending bit goes high after the clock edge at which the selected outgoing flag is sampled 0, provided it was sampled 1 at the edge before and the drain enable is 1.
- R5: A pending bit stays set until it is cleared. Flags that are not selected have no effect on it.
- R6: A clear pulse of 1 drops the pending bit at the next edge. If a qualifying event happens at that same edge, the bit stays set.
- R7: A change of mailbox select or byte select never creates an event, even when the new flag differs from the old one. The next comparison uses the newly selected flag.
- R8: While a condition's enable is 0, its events are dropped. A pending bit that is already set keeps its value.
- R9: `irq_n` is 0 exactly when at least one pending bit is 1. It changes at the same edge as the pending bits.
- R10: The two conditions are independent. A clear, enable or select of one condition has no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_full | input | 16 | Incoming mailbox byte-full flags |
| out_full | input | 16 | Outgoing mailbox byte-full flags |
| arr_en | input | 1 | Arrival condition enable |
| arr_mb | input | 2 | Arrival mailbox select |
| arr_byte | input | 2 | Arrival byte select |
| arr_clr | input | 1 | Arrival pending clear, write-one pulse |
| drn_en | input | 1 | Drain condition enable |
| drn_mb | input | 2 | Drain mailbox select |
| drn_byte | input | 2 | Drain byte select |
| drn_clr | input | 1 | Drain pending clear, write-one pulse |
| arr_pend | output | 1 | Arrival pending bit |
| drn_pend | output | 1 | Drain pending bit |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Directed steps come first:
- Holding all flags full through reset shows whether a spurious arrival appears after reset.
- Moving a single bit at index 9 shows whether the index is decoded correctly.
- Switching selects onto a flag with a different value shows whether a select change is wrongly taken as an edge.
- Clearing in the same cycle as a new edge shows which of the two wins.

The random phase then mixes sparse flag toggles, select changes, enable drops and clear pulses. This phase shows whether edge polarity is right, whether the pending bits stay sticky, and whether the two conditions stay separate.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  // Which flag transition counts as an event
  typedef enum logic {
    EDGE_FILL  = 1'b1,
    EDGE_DRAIN = 1'b0
  } edge_kind_e;

  localparam int DEF_MB_CNT   = 4;
  localparam int DEF_MB_BYTES = 4;
endpackage

// File: rtl/mbx_flag_edge.sv
module mbx_flag_edge
  import mbx_irq_pkg::*;
#(
  parameter int         FLAG_W = 16,
  parameter int         IDX_W  = $clog2(FLAG_W),
  parameter edge_kind_e KIND   = EDGE_FILL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags,
  input  logic [IDX_W-1:0]  idx,
  output logic              evt
);
  logic             cur;
  logic             prev_q;
  logic             armed_q;
  logic [IDX_W-1:0] idx_q;
  logic             trans;

  assign cur = flags[idx];

  generate
    if (KIND == EDGE_FILL) begin : g_fill
      assign trans = cur & ~prev_q;
    end else begin : g_drain
      assign trans = ~cur & prev_q;
    end
  endgenerate

  // An event needs a captured sample taken from the same selected flag
  assign evt = armed_q && (idx == idx_q) && trans;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      prev_q  <= cur;
      armed_q <= 1'b1;
      idx_q   <= idx;
    end
  end

  // R1
  first_after_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !evt);
endmodule

// File: rtl/mbx_irq_pend.sv
module mbx_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic en,
  input  logic clr,
  output logic pend,
  output logic pend_nxt
);
  // A new event wins over a simultaneous clear
  assign pend_nxt = (evt & en) | (pend & ~clr);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= pend_nxt;
  end

  // R3
  event_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && en) |=> pend);
  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
  // R6
  clear_drops_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(evt && en)) |=> !pend);
  // R8
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && !en) |=> !pend);
endmodule

// File: rtl/mbx_event_irq.sv
module mbx_event_irq
  import mbx_irq_pkg::*;
#(
  parameter int MB_CNT   = DEF_MB_CNT,
  parameter int MB_BYTES = DEF_MB_BYTES,
  localparam int FLAG_W  = MB_CNT * MB_BYTES,
  localparam int MB_W    = $clog2(MB_CNT),
  localparam int BYTE_W  = $clog2(MB_BYTES),
  localparam int IDX_W   = $clog2(FLAG_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] in_full,
  input  logic [FLAG_W-1:0] out_full,
  input  logic              arr_en,
  input  logic [MB_W-1:0]   arr_mb,
  input  logic [BYTE_W-1:0] arr_byte,
  input  logic              arr_clr,
  input  logic              drn_en,
  input  logic [MB_W-1:0]   drn_mb,
  input  logic [BYTE_W-1:0] drn_byte,
  input  logic              drn_clr,
  output logic              arr_pend,
  output logic              drn_pend,
  output logic              irq_n
);
  logic [IDX_W-1:0] arr_idx, drn_idx;
  logic             arr_evt, drn_evt;
  logic             arr_nxt, drn_nxt;

  assign arr_idx = IDX_W'(arr_mb) * IDX_W'(MB_BYTES) + IDX_W'(arr_byte);
  assign drn_idx = IDX_W'(drn_mb) * IDX_W'(MB_BYTES) + IDX_W'(drn_byte);

  mbx_flag_edge #(.FLAG_W(FLAG_W), .IDX_W(IDX_W), .KIND(EDGE_FILL)) u_arr_edge (
    .clk(clk), .rst(rst), .flags(in_full), .idx(arr_idx), .evt(arr_evt));

  mbx_flag_edge #(.FLAG_W(FLAG_W), .IDX_W(IDX_W), .KIND(EDGE_DRAIN)) u_drn_edge (
    .clk(clk), .rst(rst), .flags(out_full), .idx(drn_idx), .evt(drn_evt));

  mbx_irq_pend u_arr_pend (
    .clk(clk), .rst(rst), .evt(arr_evt), .en(arr_en), .clr(arr_clr),
    .pend(arr_pend), .pend_nxt(arr_nxt));

  mbx_irq_pend u_drn_pend (
    .clk(clk), .rst(rst), .evt(drn_evt), .en(drn_en), .clr(drn_clr),
    .pend(drn_pend), .pend_nxt(drn_nxt));

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(arr_nxt | drn_nxt);
  end

  // R9
  irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(arr_pend || drn_pend));
  // R7
  arr_sel_change_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(arr_idx) && !arr_pend) |=> !arr_pend);
  // R7
  drn_sel_change_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(drn_idx) && !drn_pend) |=> !drn_pend);
endmodule

// File: tb/mbx_event_irq_test.sv
`timescale 1ns/1ps
module mbx_event_irq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] in_full, out_full;
  logic        arr_en, arr_clr, drn_en, drn_clr;
  logic [1:0]  arr_mb, arr_byte, drn_mb, drn_byte;
  logic        arr_pend, drn_pend, irq_n;

  int tests = 0;
  int fails = 0;

  // Reference state
  logic m_valid, m_ap, m_dp, m_pa, m_pd;
  int   m_aidx, m_didx;

  always #2 clk = ~clk;

  mbx_event_irq uut (
    .clk(clk), .rst(rst), .in_full(in_full), .out_full(out_full),
    .arr_en(arr_en), .arr_mb(arr_mb), .arr_byte(arr_byte), .arr_clr(arr_clr),
    .drn_en(drn_en), .drn_mb(drn_mb), .drn_byte(drn_byte), .drn_clr(drn_clr),
    .arr_pend(arr_pend), .drn_pend(drn_pend), .irq_n(irq_n));

  function automatic int flag_index(input logic [1:0] mb, input logic [1:0] b);
    return int'(mb) * 4 + int'(b); // R2 mapping
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int  ai, di;
    logic ca, cd, ea, ed;
    if (rst) begin
      m_valid = 0; m_ap = 0; m_dp = 0; m_pa = 0; m_pd = 0; m_aidx = 0; m_didx = 0;
    end else begin
      ai = flag_index(arr_mb, arr_byte);
      di = flag_index(drn_mb, drn_byte);
      ca = in_full[ai];
      cd = out_full[di];
      ea = m_valid && (ai == m_aidx) && ca && !m_pa;
      ed = m_valid && (di == m_didx) && !cd && m_pd;
      m_ap = (ea && arr_en) || (m_ap && !arr_clr);
      m_dp = (ed && drn_en) || (m_dp && !drn_clr);
      m_pa = ca; m_pd = cd; m_aidx = ai; m_didx = di; m_valid = 1;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "arr_pend", arr_pend, m_ap);
    check(tag, "drn_pend", drn_pend, m_dp);
    check(tag, "irq_n", irq_n, !(m_ap || m_dp));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; in_full = '1; out_full = '0;
    arr_en = 1; drn_en = 1; arr_clr = 0; drn_clr = 0;
    arr_mb = 0; arr_byte = 0; drn_mb = 0; drn_byte = 0;
    @(negedge clk);
    repeat (3) step("R1 reset");
    rst = 0;
    step("R1 first edge");
    step("R1 flags held");
    check("R1", "arr_pend after full flags", arr_pend, 1'b0);

    // R2/R3: mailbox 2, byte 1 -> bit 9
    in_full = '0; arr_mb = 2; arr_byte = 1;
    step("R2 setup");
    in_full[8] = 1; step("R2 neighbour bit");
    check("R2", "bit 8 ignored", arr_pend, 1'b0);
    in_full[9] = 1; step("R3 fill edge");
    check("R3", "bit 9 fill", arr_pend, 1'b1);
    check("R9", "irq low", irq_n, 1'b0);

    // R6: clear together with a new edge
    in_full[9] = 0; step("R5 hold");
    in_full[9] = 1; arr_clr = 1; step("R6 clear vs event");
    check("R6", "event wins", arr_pend, 1'b1);
    step("R6 clear");
    arr_clr = 0;
    check("R6", "cleared", arr_pend, 1'b0);

    // R7: switch to byte 2 (bit 10 = 0) then to bit 8 (=1) with no event
    in_full[10] = 0; arr_byte = 2; step("R7 switch");
    arr_byte = 0; step("R7 switch to full flag");
    check("R7", "no event on select", arr_pend, 1'b0);

    // R4: mailbox 3 byte 3 -> bit 15
    drn_mb = 3; drn_byte = 3; out_full[15] = 1; step("R4 setup");
    out_full[15] = 0; step("R4 drain edge");
    check("R4", "drain", drn_pend, 1'b1);

    // R8: disabled fill edge dropped, drain pending kept
    arr_en = 0; drn_en = 0; in_full[8] = 0; step("R8 prep");
    in_full[8] = 1; step("R8 disabled edge");
    check("R8", "arr dropped", arr_pend, 1'b0);
    check("R8", "drn kept", drn_pend, 1'b1);
    arr_en = 1; drn_en = 1;

    // R10: clearing arrival leaves drain untouched
    arr_clr = 1; step("R10 other clear");
    arr_clr = 0;
    check("R10", "drn untouched", drn_pend, 1'b1);
    drn_clr = 1; step("R9 clear all");
    drn_clr = 0;
    check("R9", "irq released", irq_n, 1'b1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      in_full  = in_full  ^ (($urandom % 3 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0);
      out_full = out_full ^ (($urandom % 3 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0);
      if ($urandom % 16 == 0) begin arr_mb = 2'($urandom); arr_byte = 2'($urandom); end
      if ($urandom % 16 == 0) begin drn_mb = 2'($urandom); drn_byte = 2'($urandom); end
      arr_en  = ($urandom % 10) != 0;
      drn_en  = ($urandom % 10) != 0;
      arr_clr = ($urandom % 8) == 0;
      drn_clr = ($urandom % 8) == 0;
      if ($urandom % 1000 == 0) rst = 1; else rst = 0;
      step("R5 R10 random");
    end
    rst = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule